// File: doc/BRIEF.md
# Indirect-Addressed Host Register Port

This block is a byte-wide host port with two address pins. The host loads an 8-bit index into an internal pointer, then moves data to or from the register that the pointer selects. The same port also pops bytes from a sliced-data FIFO and reads or clears an interrupt status byte. The indexed space has three parts. The low part (00h–8Fh) is served by a slow backend through a req/ack handshake. The middle part (90h–CFh) answers at once. Indexes D0h–FFh are unmapped.

For a slow index, loading the pointer starts a backend read, and a data write starts a backend write. A level flag in the status byte drops while a slow cycle is pending and returns when the backend acknowledges. The same acknowledge latches a sticky completion flag, which can drive the interrupt line through an enable register held inside the block at index C1h. Fast accesses never touch that flag. A data write to index 7Fh sets a start output that stays set until reset.

Top module: `hostRegPort`

## Requirements
- R1: The two host address bits select the operation. 00 writes the index pointer, and a read at 00 returns the pointer. 01 moves register data. 10 reads the FIFO. 11 reads the status byte or writes a clear mask to it.
- R2: Writing an index in 00h–8Fh while no slow cycle is pending raises beReq with beWrite=0 and regAddr equal to the index. On a beAck cycle, beReq drops and beRdData is captured. A later data read (01) returns the captured byte.
- R3: A data write (01) while the pointer is in 00h–8Fh and no slow cycle is pending raises beReq with beWrite=1. beReq, beWrite, regAddr and regWrData hold steady until beAck, for any latency.
- R4: Status bit 0 is the cycle-complete level. It is 1 after reset, 0 from the cycle after a slow cycle starts, and 1 again after its acknowledge.
- R5: Each slow-cycle acknowledge sets status bit 1, the completion flag. Fast-region and unmapped accesses never raise beReq and never set bit 1.
- R6: In 90h–CFh, a data read returns fastRdData, and a data write pulses fastWrEn for one cycle after the write. Index C1h is an exception: it reads and writes the internal 8-bit enable register and does not pulse fastWrEn.
- R7: Status bits 1..7 are sticky. Bits 2..7 are set by evtIn[0..5]. Writing a byte at address 11 clears each bit whose mask bit is 1 and leaves bits with mask 0 unchanged. A bit that is set in the same cycle as its clear stays set.
- R8: irq is high exactly when some status bit k in 1..7 and enable bit k are both 1. Enable bit 0 has no effect.
- R9: A read at 10 returns fifoData and asserts fifoPop when fifoEmpty is 0. When fifoEmpty is 1 it returns 00h and fifoPop stays 0.
- R10: startOut is 0 after reset. A data write to index 7Fh sets it, and it stays 1 until the next reset whatever is written afterwards.
- R11: For indexes D0h–FFh, a data read returns 00h, and a data write raises neither beReq nor fastWrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 2 | Host operation select |
| hostWrEn | input | 1 | Host write strobe, one cycle per access |
| hostRdEn | input | 1 | Host read strobe, one cycle per access |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, combinational on hostAddr |
| irq | output | 1 | Interrupt to host |
| startOut | output | 1 | Latched device start |
| regAddr | output | 8 | Current index pointer, shared by backend and fast space |
| regWrData | output | 8 | Last data byte written through address 01 |
| beReq | output | 1 | Slow backend request, held until ack |
| beWrite | output | 1 | Slow request direction, 1 means write |
| beAck | input | 1 | Slow backend acknowledge, one cycle |
| beRdData | input | 8 | Slow backend read byte, valid with beAck |
| fastWrEn | output | 1 | Fast-space write pulse |
| fastRdData | input | 8 | Fast-space read byte for regAddr |
| fifoData | input | 8 | FIFO head byte |
| fifoEmpty | input | 1 | FIFO empty flag |
| fifoPop | output | 1 | FIFO pop strobe |
| evtIn | input | 6 | Event pulses that set status bits 2..7 |

## Verification
Two functions can meet in one cycle on the status byte: a backend acknowledge or an event pulse setting a flag, and a host write-1 clear of that same flag. The bench provokes this by driving beAck together with a clear mask of 02h, and separately evtIn[0] together with a clear mask of 04h, on the same clock edge. It then reads the status byte and expects the flag still set. A following clear-only write must remove the flag. The irq line is judged against the AND of the enable and flag patterns for all 256 enable values under two flag patterns.

// File: rtl/hrpPkg.sv
package hrpPkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'b00,
    SEL_DATA = 2'b01,
    SEL_FIFO = 2'b10,
    SEL_STAT = 2'b11
  } hostSel_e;

  typedef struct packed {
    logic loadPtr;
    logic dataWr;
    logic fifoRd;
    logic statWr;
    logic launch;
    logic ackTake;
  } ctrlStrb_t;
endpackage

// File: rtl/hrpControl.sv
module hrpControl
  import hrpPkg::*;
#(
  parameter logic [DW-1:0] SLOW_MAX = 8'h8F
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    hostAddr,
  input  logic          hostWrEn,
  input  logic          hostRdEn,
  input  logic [DW-1:0] hostWrData,
  input  logic [DW-1:0] ptrReg,
  input  logic          beAck,
  output ctrlStrb_t     strb,
  output logic          beReq,
  output logic          beWrite
);
  hostSel_e sel;
  logic launchRd, launchWr;

  assign sel = hostSel_e'(hostAddr);

  always_comb begin
    strb.loadPtr = hostWrEn && (sel == SEL_PTR);
    strb.dataWr  = hostWrEn && (sel == SEL_DATA);
    strb.fifoRd  = hostRdEn && (sel == SEL_FIFO);
    strb.statWr  = hostWrEn && (sel == SEL_STAT);
    launchRd     = strb.loadPtr && (hostWrData <= SLOW_MAX) && !beReq;
    launchWr     = strb.dataWr && (ptrReg <= SLOW_MAX) && !beReq;
    strb.launch  = launchRd || launchWr;
    strb.ackTake = beReq && beAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beReq   <= 1'b0;
      beWrite <= 1'b0;
    end else if (strb.ackTake) begin
      beReq <= 1'b0;
    end else if (strb.launch) begin
      beReq   <= 1'b1;
      beWrite <= launchWr;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && !beAck) |=> (beReq && $stable(beWrite)));

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && beAck) |=> !beReq);
endmodule

// File: rtl/hrpDatapath.sv
module hrpDatapath
  import hrpPkg::*;
#(
  parameter int            NUM_EVT     = 6,
  parameter logic [DW-1:0] SLOW_MAX    = 8'h8F,
  parameter logic [DW-1:0] FAST_MIN    = 8'h90,
  parameter logic [DW-1:0] FAST_MAX    = 8'hCF,
  parameter logic [DW-1:0] IRQ_EN_IDX  = 8'hC1,
  parameter logic [DW-1:0] START_IDX   = 8'h7F
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [1:0]         hostAddr,
  input  logic [DW-1:0]      hostWrData,
  input  logic               beWrite,
  input  logic [DW-1:0]      beRdData,
  input  logic [DW-1:0]      fastRdData,
  input  logic [DW-1:0]      fifoData,
  input  logic               fifoEmpty,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic [DW-1:0]      ptrReg,
  output logic [DW-1:0]      wrDataReg,
  output logic [DW-1:0]      hostRdData,
  output logic               fifoPop,
  output logic               fastWrEn,
  output logic               irq,
  output logic               startOut
);
  localparam int FLAG_W = NUM_EVT + 1;

  logic [DW-1:0]     readBuf;
  logic [DW-1:0]     enReg;
  logic              cycleDone;
  logic [FLAG_W-1:0] flags, flagsNext, setVec;
  logic [DW-1:0]     statusByte;
  logic              inSlow, inFast, isEnIdx;

  assign inSlow  = ptrReg <= SLOW_MAX;
  assign inFast  = (ptrReg >= FAST_MIN) && (ptrReg <= FAST_MAX);
  assign isEnIdx = ptrReg == IRQ_EN_IDX;
  assign setVec  = {evtIn, strb.ackTake};

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    assign flagsNext[k] = setVec[k] ||
                          (flags[k] && !(strb.statWr && hostWrData[k+1]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg    <= '0;
      wrDataReg <= '0;
      readBuf   <= '0;
      enReg     <= '0;
      cycleDone <= 1'b1;
      flags     <= '0;
      fastWrEn  <= 1'b0;
      startOut  <= 1'b0;
    end else begin
      flags    <= flagsNext;
      fastWrEn <= strb.dataWr && inFast && !isEnIdx;
      if (strb.loadPtr) ptrReg <= hostWrData;
      if (strb.dataWr) wrDataReg <= hostWrData;
      if (strb.dataWr && isEnIdx) enReg <= hostWrData;
      if (strb.dataWr && (ptrReg == START_IDX)) startOut <= 1'b1;
      if (strb.ackTake && !beWrite) readBuf <= beRdData;
      if (strb.ackTake) cycleDone <= 1'b1;
      else if (strb.launch) cycleDone <= 1'b0;
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[FLAG_W:0] = {flags, cycleDone};
    irq = |(flags & enReg[FLAG_W:1]);
    fifoPop = strb.fifoRd && !fifoEmpty;
    unique case (hostSel_e'(hostAddr))
      SEL_PTR:  hostRdData = ptrReg;
      SEL_DATA: begin
        if (inSlow)       hostRdData = readBuf;
        else if (isEnIdx) hostRdData = enReg;
        else if (inFast)  hostRdData = fastRdData;
        else              hostRdData = '0;
      end
      SEL_FIFO: hostRdData = fifoEmpty ? '0 : fifoData;
      SEL_STAT: hostRdData = statusByte;
      default:  hostRdData = '0;
    endcase
  end

  // R4
  done_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> !cycleDone);

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> (flags[0] && cycleDone));

  // R10
  start_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    startOut |=> startOut);

  // R9
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);
endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hrpPkg::*;
#(
  parameter int            NUM_EVT    = 6,
  parameter logic [DW-1:0] SLOW_MAX   = 8'h8F,
  parameter logic [DW-1:0] FAST_MIN   = 8'h90,
  parameter logic [DW-1:0] FAST_MAX   = 8'hCF,
  parameter logic [DW-1:0] IRQ_EN_IDX = 8'hC1,
  parameter logic [DW-1:0] START_IDX  = 8'h7F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         hostAddr,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [DW-1:0]      hostWrData,
  output logic [DW-1:0]      hostRdData,
  output logic               irq,
  output logic               startOut,
  output logic [DW-1:0]      regAddr,
  output logic [DW-1:0]      regWrData,
  output logic               beReq,
  output logic               beWrite,
  input  logic               beAck,
  input  logic [DW-1:0]      beRdData,
  output logic               fastWrEn,
  input  logic [DW-1:0]      fastRdData,
  input  logic [DW-1:0]      fifoData,
  input  logic               fifoEmpty,
  output logic               fifoPop,
  input  logic [NUM_EVT-1:0] evtIn
);
  ctrlStrb_t strb;

  hrpControl #(.SLOW_MAX(SLOW_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .ptrReg(regAddr),
    .beAck(beAck), .strb(strb), .beReq(beReq), .beWrite(beWrite)
  );

  hrpDatapath #(
    .NUM_EVT(NUM_EVT), .SLOW_MAX(SLOW_MAX), .FAST_MIN(FAST_MIN),
    .FAST_MAX(FAST_MAX), .IRQ_EN_IDX(IRQ_EN_IDX), .START_IDX(START_IDX)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .beWrite(beWrite), .beRdData(beRdData),
    .fastRdData(fastRdData), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .evtIn(evtIn), .ptrReg(regAddr), .wrDataReg(regWrData),
    .hostRdData(hostRdData), .fifoPop(fifoPop), .fastWrEn(fastWrEn),
    .irq(irq), .startOut(startOut)
  );
endmodule

// File: tb/sim_hostRegPort.sv
module sim_hostRegPort;
  localparam int LONG_WAIT = 16000;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] hostAddr = '0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostWrData = '0, hostRdData;
  logic irq, startOut, beReq, beWrite, fastWrEn, fifoPop;
  logic [7:0] regAddr, regWrData;
  logic beAck = 1'b0;
  logic [7:0] beRdData = '0, fifoData = '0;
  logic fifoEmpty = 1'b1;
  logic [5:0] evtIn = '0;
  logic [7:0] fastRdData;
  int total = 0, failed = 0;
  bit finished = 0;

  assign fastRdData = regAddr ^ 8'h5A;

  always #2 clk = ~clk;

  hostRegPort u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .irq(irq), .startOut(startOut), .regAddr(regAddr), .regWrData(regWrData),
    .beReq(beReq), .beWrite(beWrite), .beAck(beAck), .beRdData(beRdData),
    .fastWrEn(fastWrEn), .fastRdData(fastRdData), .fifoData(fifoData),
    .fifoEmpty(fifoEmpty), .fifoPop(fifoPop), .evtIn(evtIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk);
    hostAddr = a; hostRdEn = 1'b1;
    #1 d = hostRdData; pop = fifoPop;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic doAck(input logic [7:0] d);
    @(negedge clk);
    beAck = 1'b1; beRdData = d;
    @(negedge clk);
    beAck = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  function automatic bit isSlow(input logic [7:0] a); return a <= 8'h8F; endfunction
  function automatic bit isFast(input logic [7:0] a); return a >= 8'h90 && a <= 8'hCF; endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d, expD;
    logic pop;
    int bad;
    doReset();
    // reset state (R4, R10, R8, R1)
    hostRead(2'b11, d, pop); chk("R4 reset status", d, 8'h01);
    chk("R10 reset start", startOut, 0);
    chk("R8 reset irq", irq, 0);
    chk("R2 reset req", beReq, 0);
    hostRead(2'b00, d, pop); chk("R1 reset ptr", d, 8'h00);

    // sweep all indexes: pointer load and data read (R1 R2 R4 R5 R6 R11)
    for (int i = 0; i < 256; i++) begin
      logic [7:0] a;
      a = i[7:0];
      hostWrite(2'b00, a);
      chk("R2 R5 R11 req on load", beReq, isSlow(a));
      hostRead(2'b00, d, pop); chk("R1 ptr readback", d, a);
      if (isSlow(a)) begin
        chk("R2 direction", beWrite, 0);
        chk("R2 regAddr", regAddr, a);
        hostRead(2'b11, d, pop); chk("R4 pending bit", d[0], 0);
        doAck(a ^ 8'hFF);
        chk("R2 req dropped", beReq, 0);
        expD = a ^ 8'hFF;
      end else if (a == 8'hC1) expD = 8'h00;
      else if (isFast(a)) expD = a ^ 8'h5A;
      else expD = 8'h00;
      hostRead(2'b01, d, pop); chk("R2 R6 R11 data read", d, expD);
    end

    // sweep all indexes: data write (R3 R6 R10 R11)
    for (int i = 0; i < 256; i++) begin
      logic [7:0] a;
      a = i[7:0];
      hostWrite(2'b00, a);
      if (isSlow(a)) doAck(8'h00);
      hostWrite(2'b01, a ^ 8'h33);
      chk("R3 R11 req on write", beReq, isSlow(a));
      chk("R6 R11 fast pulse", fastWrEn, isFast(a) && a != 8'hC1);
      chk("R10 start level", startOut, a >= 8'h7F);
      if (isSlow(a)) begin
        chk("R3 direction", beWrite, 1);
        chk("R3 data", regWrData, a ^ 8'h33);
        doAck(8'h00);
      end
    end
    hostWrite(2'b00, 8'hC1);
    hostRead(2'b01, d, pop); chk("R6 enable readback", d, 8'hF2);

    // completion flag and irq (R4 R5 R7 R8)
    hostRead(2'b11, d, pop); chk("R5 status after acks", d, 8'h03);
    chk("R8 irq on done flag", irq, 1);
    hostWrite(2'b11, 8'h00);
    hostRead(2'b11, d, pop); chk("R7 zero mask keeps", d, 8'h03);
    hostWrite(2'b11, 8'h02);
    hostRead(2'b11, d, pop); chk("R7 clear bit1", d, 8'h01);
    chk("R8 irq cleared", irq, 0);

    // same-cycle set and clear (R7)
    hostWrite(2'b00, 8'h20);
    @(negedge clk);
    hostAddr = 2'b11; hostWrData = 8'h02; hostWrEn = 1'b1; beAck = 1'b1; beRdData = 8'h77;
    @(negedge clk);
    hostWrEn = 1'b0; beAck = 1'b0;
    hostRead(2'b11, d, pop); chk("R7 ack beats clear", d, 8'h03);
    @(negedge clk);
    hostAddr = 2'b11; hostWrData = 8'h04; hostWrEn = 1'b1; evtIn = 6'h01;
    @(negedge clk);
    hostWrEn = 1'b0; evtIn = '0;
    hostRead(2'b11, d, pop); chk("R7 event beats clear", d, 8'h07);
    hostWrite(2'b11, 8'h06);
    hostRead(2'b11, d, pop); chk("R7 clear only", d, 8'h01);

    // irq against every enable value, two flag patterns (R8)
    @(negedge clk); evtIn = 6'h3F; @(negedge clk); evtIn = '0;
    hostWrite(2'b00, 8'h05); doAck(8'h00);
    hostRead(2'b11, d, pop); chk("R7 all flags", d, 8'hFF);
    hostWrite(2'b00, 8'hC1);
    for (int e = 0; e < 256; e++) begin
      hostWrite(2'b01, e[7:0]);
      chk("R8 irq full flags", irq, |(e[7:0] & 8'hFE));
    end
    hostWrite(2'b11, 8'hAA);
    hostRead(2'b11, d, pop); chk("R7 mask AA", d, 8'h55);
    for (int e = 0; e < 256; e++) begin
      hostWrite(2'b01, e[7:0]);
      chk("R8 irq partial flags", irq, |(e[7:0] & 8'h54));
    end

    // FIFO (R9)
    fifoEmpty = 1'b1; fifoData = 8'h9C;
    hostRead(2'b10, d, pop); chk("R9 empty data", d, 8'h00); chk("R9 empty pop", pop, 0);
    fifoEmpty = 1'b0;
    hostRead(2'b10, d, pop); chk("R9 data", d, 8'h9C); chk("R9 pop", pop, 1);

    // long backend write wait (R3 R4)
    hostWrite(2'b00, 8'h10); doAck(8'h00);
    hostWrite(2'b01, 8'h3C);
    bad = 0;
    for (int c = 0; c < LONG_WAIT; c++) begin
      @(negedge clk);
      if (!beReq || !beWrite || regWrData != 8'h3C || regAddr != 8'h10) bad++;
    end
    chk("R3 held over long wait", bad, 0);
    hostRead(2'b11, d, pop); chk("R4 pending after wait", d[0], 0);
    doAck(8'h00);
    hostRead(2'b11, d, pop); chk("R4 done after ack", d[0], 1);

    // start stays, reset clears (R10)
    hostWrite(2'b00, 8'h7F); doAck(8'h00);
    hostWrite(2'b01, 8'h00); doAck(8'h00);
    chk("R10 start still set", startOut, 1);
    doReset();
    chk("R10 start cleared by reset", startOut, 0);
    hostRead(2'b11, d, pop); chk("R4 status after reset", d, 8'h01);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule